// File: doc/BRIEF.md
# Protected-Region Serial Read Responder

This block is the device-side logic of a serial memory that answers one command: a single-line read of a small one-time-programmable region. It runs directly on the serial clock. Chip select, active low, opens a transaction. On the input line the host sends an 8-bit command code, a 24-bit start address sent most significant bit first, and then one byte that the block ignores. The block captures every one of these bits on a rising clock edge.

Read data then leaves on the output line, one bit per falling clock edge, most significant bit first. The byte address moves up by one after each byte. The protected region holds 65 bytes and sits behind a combinational read port. Addresses past the region never wrap back to zero. Instead they return a fixed filler byte.

A busy flag from the erase/program controller is sampled as the command code completes. If the flag is set, the block drops the command and leaves the running cycle untouched. Raising chip select ends the transaction at once.

Top module: `otp_read_responder`

## Requirements
- R1: While `cs_n` is high the block is idle: `so_en` and `so` are both 0.
- R2: `so_en` stays 0 for the first 40 rising edges after `cs_n` falls. These edges carry 8 command bits, then 24 address bits (MSB first), then 8 ignored bits.
- R3: After the 40th rising edge, each falling edge drives one data bit on `so` with `so_en` = 1. The bits go out MSB first. The first byte is the region byte at the captured address, read through `arr_addr` (address bits 6:0) and `arr_data`.
- R4: After every 8 data bits the byte address rises by one, and output continues without a gap for as long as `cs_n` stays low.
- R5: A byte whose full 24-bit address is 65 or more is driven as 0xFF. For example, address 64 is followed by filler, not by address 0. Address 0x000103 also reads as filler.
- R6: A command code other than 0x4B is ignored. `so_en` stays 0 until `cs_n` rises.
- R7: `busy` is sampled only on the 8th rising edge, where the last command bit is captured. If it is 1 there, the transaction is rejected and `so_en` stays 0. A `busy` value of 1 on any other edge has no effect.
- R8: A rise of `cs_n` at any point, in the header or in mid-byte, immediately forces `so_en` and `so` to 0. The next transaction starts from a clean header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; inputs are captured on the rising edge, output moves on the falling edge |
| cs_n | input | 1 | Chip select, active low; high resets the block asynchronously |
| si | input | 1 | Serial input line (command, address, ignored byte) |
| busy | input | 1 | Erase/program/write cycle in progress |
| so | output | 1 | Serial data output |
| so_en | output | 1 | Output drive enable; 0 means the pad is high impedance |
| arr_addr | output | 7 | Index into the 65-byte region |
| arr_data | input | 8 | Byte returned by the region for `arr_addr` (combinational) |

## Verification
The header produces no output for 40 rising edges. The first data bit appears half a clock after the 40th rising edge, and each later bit follows one falling edge after the one before it. The bench therefore checks `so_en` 2 ns after each header rising edge and checks every data bit 2 ns after its falling edge. In both cases the sample is taken well before the next rising edge. The release on `cs_n` is asynchronous, so the idle state is checked 2 ns after `cs_n` rises, with no clock edge in between. The expected bit is computed from the start address, the byte offset and the bit position. The bench uses the same region contents it presents on `arr_data`.

// File: rtl/otp_read_responder.sv
module otp_read_responder #(
  parameter logic [7:0] OPCODE       = 8'h4B,
  parameter int         REGION_BYTES = 65,
  parameter int         ADDR_BITS    = 24,
  parameter int         DUMMY_BITS   = 8,
  parameter logic [7:0] FILL         = 8'hFF,
  parameter int         IDX_W        = $clog2(REGION_BYTES)
)(
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             si,
  input  logic             busy,
  output logic             so,
  output logic             so_en,
  output logic [IDX_W-1:0] arr_addr,
  input  logic [7:0]       arr_data
);

  localparam int HDR_BITS = 8 + ADDR_BITS + DUMMY_BITS;
  localparam int CNT_W    = $clog2(HDR_BITS + 1);
  localparam logic [ADDR_BITS-1:0] LIMIT = ADDR_BITS'(REGION_BYTES);

  logic [CNT_W-1:0]     cnt;
  logic [ADDR_BITS-1:0] shreg, addr_base, byte_off;
  logic                 rejected, hdr_done, so_q;
  logic [2:0]           bidx;

  wire [ADDR_BITS-1:0] shin     = {shreg[ADDR_BITS-2:0], si};
  wire [ADDR_BITS-1:0] cur_addr = addr_base + byte_off;
  wire [7:0]           cur_byte = (cur_addr < LIMIT) ? arr_data : FILL;

  assign arr_addr = cur_addr[IDX_W-1:0];
  assign so       = so_en & so_q;

  always_ff @(posedge sclk or posedge cs_n) begin
    if (cs_n) begin
      cnt       <= '0;
      shreg     <= '0;
      addr_base <= '0;
      rejected  <= 1'b0;
      hdr_done  <= 1'b0;
    end else begin
      shreg <= shin;
      if (cnt != CNT_W'(HDR_BITS)) cnt <= cnt + 1'b1;
      if (cnt == CNT_W'(7) && (shin[7:0] != OPCODE || busy)) rejected <= 1'b1;
      if (cnt == CNT_W'(8 + ADDR_BITS - 1)) addr_base <= shin;
      if (cnt == CNT_W'(HDR_BITS - 1) && !rejected) hdr_done <= 1'b1;
    end
  end

  always_ff @(negedge sclk or posedge cs_n) begin
    if (cs_n) begin
      so_en    <= 1'b0;
      so_q     <= 1'b0;
      bidx     <= '0;
      byte_off <= '0;
    end else if (hdr_done) begin
      so_en <= 1'b1;
      so_q  <= cur_byte[~bidx];
      bidx  <= bidx + 1'b1;
      if (&bidx) byte_off <= byte_off + 1'b1;
    end
  end

  assert_quiet_header_R2: assert property (@(posedge sclk) disable iff (cs_n)
    !hdr_done |-> !so_en);

  assert_reject_silent_R6: assert property (@(posedge sclk) disable iff (cs_n)
    rejected |-> !hdr_done && !so_en);

  assert_output_held_R3: assert property (@(negedge sclk) disable iff (cs_n)
    $past(so_en) |-> so_en);

  assert_addr_step_R4: assert property (@(negedge sclk) disable iff (cs_n)
    (so_en && bidx == 3'd0) |-> byte_off == $past(byte_off) + 1'b1);

  assert_first_bit_R3: assert property (@(negedge sclk) disable iff (cs_n)
    $rose(so_en) |-> bidx == 3'd1 && byte_off == '0);

endmodule

// File: tb/sim_otp_read_responder.sv
module sim_otp_read_responder;
  logic       sclk = 1'b0;
  logic       cs_n = 1'b1;
  logic       si = 1'b0;
  logic       busy = 1'b0;
  logic       so, so_en;
  logic [6:0] arr_addr;
  logic [7:0] arr_data;
  int         checks = 0;
  int         bad = 0;

  always #4 sclk = ~sclk;

  function automatic logic [7:0] mem_fn(input logic [6:0] i);
    logic [7:0] t;
    t = {1'b0, i};
    return t * 8'd29 + 8'd7;
  endfunction

  function automatic logic [7:0] exp_byte(input logic [23:0] a);
    return (a < 24'd65) ? mem_fn(a[6:0]) : 8'hFF;
  endfunction

  assign arr_data = mem_fn(arr_addr);

  otp_read_responder u0 (
    .sclk(sclk), .cs_n(cs_n), .si(si), .busy(busy),
    .so(so), .so_en(so_en), .arr_addr(arr_addr), .arr_data(arr_data));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // bmode: 0 none, 1 busy on the command's last bit, 2 busy on every other bit
  task automatic txn(input logic [7:0] op, input logic [23:0] addr, input int bmode,
                     input int hdr_bits, input int data_bits);
    logic [39:0] hdr;
    logic [7:0]  eb;
    logic [23:0] a;
    bit          ok;
    string       req;
    hdr = {op, addr, 8'h00};
    ok  = (op == 8'h4B) && (bmode != 1) && (hdr_bits == 40);
    @(negedge sclk);
    cs_n = 1'b0;
    for (int i = 0; i < hdr_bits; i++) begin
      si   = hdr[39-i];
      busy = (bmode == 1 && i == 7) || (bmode == 2 && i != 7);
      @(posedge sclk);
      #2;
      check(so_en == 1'b0, "R2", so_en, 0);
      @(negedge sclk);
    end
    busy = 1'b0;
    for (int j = 0; j < data_bits; j++) begin
      si = 1'($urandom_range(0, 1));
      #2;
      if (ok) begin
        a  = addr + 24'(j / 8);
        eb = exp_byte(a);
        req = (a >= 24'd65) ? "R5" : ((j >= 8) ? "R4" : "R3");
        check(so_en && so == eb[7 - (j % 8)], req, {so_en, so}, {1'b1, eb[7 - (j % 8)]});
      end else begin
        req = (op != 8'h4B) ? "R6" : "R7";
        check(so_en == 1'b0, req, so_en, 0);
      end
      @(negedge sclk);
    end
    cs_n = 1'b1;
    #2;
    check(so_en == 1'b0 && so == 1'b0, "R8", {so_en, so}, 0);
    repeat (2) @(negedge sclk);
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    checks++;
    $display("FAIL watchdog expired (R8 flow hung)");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge sclk);
    #2;
    check(so_en == 1'b0 && so == 1'b0, "R1", {so_en, so}, 0);

    txn(8'h4B, 24'd0, 0, 40, 24);          // R3, R4 from start of region
    txn(8'h4B, 24'd62, 0, 40, 40);         // R5 crosses 64 into filler
    txn(8'h4B, 24'h000103, 0, 40, 16);     // R5 high address bits count
    txn(8'h03, 24'd5, 0, 40, 16);          // R6 wrong command code
    txn(8'h4B, 24'd5, 1, 40, 16);          // R7 busy at command end
    txn(8'h4B, 24'd9, 2, 40, 16);          // R7 busy elsewhere ignored
    txn(8'h4B, 24'd20, 0, 40, 11);         // R8 abort mid-byte
    txn(8'h4B, 24'd10, 0, 40, 16);
    txn(8'h4B, 24'd30, 0, 20, 0);          // R8 abort in header
    txn(8'h4B, 24'd64, 0, 40, 16);         // R5 last region byte then filler
    #2;
    check(so_en == 1'b0, "R1", so_en, 0);

    for (int k = 0; k < 24; k++) begin
      logic [23:0] ra;
      logic [7:0]  rop;
      int          nb, bm, cut;
      ra  = ($urandom_range(0, 3) == 0) ? 24'($urandom) : 24'($urandom_range(0, 70));
      rop = ($urandom_range(0, 7) == 0) ? 8'h03 : 8'h4B;
      bm  = ($urandom_range(0, 5) == 0) ? 1 : (($urandom_range(0, 4) == 0) ? 2 : 0);
      nb  = $urandom_range(1, 5);
      cut = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 7) : 0;
      txn(rop, ra, bm, 40, nb * 8 - cut);
    end

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule